// File: doc/BRIEF.md
# Lockable Key-Hash Register Guard

This block holds a 256-bit root-key digest as four 64-bit registers and decides, on every write, whether that digest may change. The decision draws on two other registers in the same block. One is a feature-control register with a lock bit and a launch-control bit. The other is a one-shot activation register. A simple register port reaches all of them. Each access gives an address with a write strobe or a read strobe. Read data comes back one cycle later. A rejected write raises a one-cycle error strobe.

The rules have two phases. Before activation, early firmware may write any digest word. It may also write the feature-control register, but the enclave-related bits of that register stay cleared. After activation, the digest words accept writes only when the feature-control register is both locked and has launch control enabled. Otherwise the digest is read-only. A locked feature-control register refuses all writes until reset. Reset puts the vendor default digest back into the four words.

Top module: `keyhash_guard`

## Requirements
- R1: After reset the feature-control register reads 0, the activation register reads 0 and `err` is 0.
- R2: Before activation, a write to any digest word is accepted whatever the feature-control contents, and `err` stays 0.
- R3: After activation, a digest write is accepted if and only if feature-control bit 17 (launch control) and bit 0 (lock) are both 1.
- R4: A rejected digest write raises `err` for exactly the cycle after the write and leaves all four digest words unchanged.
- R5: Before activation, a feature-control write stores bits 17 and 18 (the enclave bits) as 0 and stores all other bits as written. After activation, all bits are stored as written.
- R6: Once feature-control bit 0 is 1, further feature-control writes are rejected with `err` and leave the register unchanged until reset.
- R7: Writing data with bit 0 set to address 0x07A sets the activation flag. The flag is sticky: writing bit 0 = 0 has no effect. The register reads back the flag in bit 0 and 0 in all other bits.
- R8: A read returns the current contents of the addressed register on `rdata` in the cycle after `req_rd`, in any lock or activation state. An unmapped address reads 0.
- R9: Digest word i (0 to 3) is at address 0x100+i. After reset it holds bits [64i+63:64i] of the default digest 256'h3b8a51c7e02f9d46_a1c5e87b09d3f226_4f1e0a9c7b35d82e_6c4190fa8d2b7e53.
- R10: `err` is raised only after a rejected write. Accepted writes, activation writes, writes to unmapped addresses and reads leave it 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Write request for the current cycle |
| req_rd | input | 1 | Read request for the current cycle |
| addr | input | 12 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid the cycle after `req_rd` |
| err | output | 1 | One-cycle strobe for a rejected write |

## Verification
The hardest state to reach from the ports is a digest write that is accepted after activation. To get there, activation must come first. Then an unlocked feature-control write must set launch control together with the lock. A lock applied earlier closes that path for good. The random episodes restart from reset many times, make lock bits rare and launch-control bits common, and so mix every order of activation, launch-control and lock writes. A directed walk steps through both the accepted order and the rejected orders explicitly.

// File: rtl/keyhash_guard_pkg.sv
package keyhash_guard_pkg;
  localparam int REG_W       = 64;
  localparam int FC_LOCK_BIT = 0;
  localparam int FC_LC_BIT   = 17;
  localparam int FC_EN_BIT   = 18;
  localparam int ACT_BIT     = 0;

  typedef logic [REG_W-1:0] word_t;

  // enclave-related feature-control bits, held at 0 before activation
  function automatic word_t enclave_mask();
    word_t m;
    m = '0;
    m[FC_LC_BIT] = 1'b1;
    m[FC_EN_BIT] = 1'b1;
    return m;
  endfunction

  function automatic word_t fc_filter(word_t wd, logic activated);
    return activated ? wd : (wd & ~enclave_mask());
  endfunction

  function automatic logic hash_wr_allowed(logic activated, word_t fc);
    return !activated || (fc[FC_LC_BIT] && fc[FC_LOCK_BIT]);
  endfunction
endpackage

// File: rtl/kg_ctrl.sv
module kg_ctrl
  import keyhash_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fc_we,
  input  logic  act_we,
  input  word_t wdata,
  output word_t fc_q,
  output logic  activated,
  output logic  fc_wr_rej
);
  logic fc_locked;
  assign fc_locked = fc_q[FC_LOCK_BIT];
  assign fc_wr_rej = fc_we && fc_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q      <= '0;
      activated <= 1'b0;
    end else begin
      if (fc_we && !fc_locked) fc_q <= fc_filter(wdata, activated);
      if (act_we && wdata[ACT_BIT]) activated <= 1'b1;
    end
  end
endmodule

// File: rtl/kg_hash_bank.sv
module kg_hash_bank
  import keyhash_guard_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 2,
  parameter logic [NUM_WORDS*REG_W-1:0] DEFAULT_HASH = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  word_t                      wdata,
  input  logic                       allowed,
  output logic [NUM_WORDS*REG_W-1:0] hash_flat,
  output logic                       wr_ok,
  output logic                       wr_rej
);
  word_t word_q [NUM_WORDS];

  assign wr_ok  = we && allowed;
  assign wr_rej = we && !allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= DEFAULT_HASH[i*REG_W +: REG_W];
    end else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (wr_ok && idx == IDX_W'(i)) word_q[i] <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
    assign hash_flat[g*REG_W +: REG_W] = word_q[g];
  end
endmodule

// File: rtl/keyhash_guard.sv
module keyhash_guard
  import keyhash_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 4,
  parameter logic [ADDR_W-1:0] FC_ADDR   = 12'h0C0,
  parameter logic [ADDR_W-1:0] ACT_ADDR  = 12'h07A,
  parameter logic [ADDR_W-1:0] HASH_BASE = 12'h100,
  parameter logic [NUM_WORDS*REG_W-1:0] DEFAULT_HASH =
    256'h3b8a51c7e02f9d46_a1c5e87b09d3f226_4f1e0a9c7b35d82e_6c4190fa8d2b7e53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              err
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  // address decode
  logic [ADDR_W-1:0] hash_off;
  logic              hit_hash, hit_fc, hit_act;
  logic [IDX_W-1:0]  hash_idx;
  assign hash_off = addr - HASH_BASE;
  assign hit_hash = (addr >= HASH_BASE) && (hash_off < ADDR_W'(NUM_WORDS));
  assign hit_fc   = (addr == FC_ADDR);
  assign hit_act  = (addr == ACT_ADDR);
  assign hash_idx = hash_off[IDX_W-1:0];

  // internal events, named for the checker
  word_t                      fc_q;
  logic                       activated;
  logic                       fc_wr_rej;
  logic                       hash_allowed;
  logic [NUM_WORDS*REG_W-1:0] hash_flat;
  logic                       hash_wr_ok, hash_wr_rej;

  kg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_we     (req_wr && hit_fc),
    .act_we    (req_wr && hit_act),
    .wdata     (wdata),
    .fc_q      (fc_q),
    .activated (activated),
    .fc_wr_rej (fc_wr_rej)
  );

  assign hash_allowed = hash_wr_allowed(activated, fc_q);

  kg_hash_bank #(
    .NUM_WORDS    (NUM_WORDS),
    .IDX_W        (IDX_W),
    .DEFAULT_HASH (DEFAULT_HASH)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (req_wr && hit_hash),
    .idx       (hash_idx),
    .wdata     (wdata),
    .allowed   (hash_allowed),
    .hash_flat (hash_flat),
    .wr_ok     (hash_wr_ok),
    .wr_rej    (hash_wr_rej)
  );

  word_t rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_fc)        rd_mux = fc_q;
    else if (hit_act)  rd_mux = REG_W'(activated);
    else if (hit_hash) rd_mux = hash_flat[hash_idx*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (req_rd) rdata <= rd_mux;
      err <= hash_wr_rej || fc_wr_rej;
    end
  end
endmodule

// File: rtl/keyhash_guard_chk.sv
module keyhash_guard_chk
  import keyhash_guard_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       err,
  input word_t                      fc_q,
  input logic                       activated,
  input logic [NUM_WORDS*REG_W-1:0] hash_flat,
  input logic                       hash_wr_ok,
  input logic                       hash_wr_rej,
  input logic                       fc_wr_rej
);
  // R4
  hash_rej_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_wr_rej |=> err);
  // R4
  hash_rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_wr_rej |=> $stable(hash_flat));
  // R3
  hash_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_wr_ok && activated) |-> (fc_q[FC_LC_BIT] && fc_q[FC_LOCK_BIT]));
  // R6
  fc_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q[FC_LOCK_BIT] |=> $stable(fc_q));
  // R7
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activated |=> activated);
  // R5
  fc_pre_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !activated |-> ((fc_q & enclave_mask()) == '0));
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(hash_wr_rej || fc_wr_rej));
endmodule

bind keyhash_guard keyhash_guard_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err         (err),
  .fc_q        (fc_q),
  .activated   (activated),
  .hash_flat   (hash_flat),
  .hash_wr_ok  (hash_wr_ok),
  .hash_wr_rej (hash_wr_rej),
  .fc_wr_rej   (fc_wr_rej)
);

// File: tb/sim_keyhash_guard.sv
module sim_keyhash_guard;
  localparam logic [11:0] FC_A  = 12'h0C0;
  localparam logic [11:0] ACT_A = 12'h07A;
  localparam logic [11:0] HB    = 12'h100;
  localparam logic [11:0] UNM_A = 12'h200;
  localparam logic [255:0] DEF =
    256'h3b8a51c7e02f9d46_a1c5e87b09d3f226_4f1e0a9c7b35d82e_6c4190fa8d2b7e53;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0, req_rd = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        err;

  always #2 clk = ~clk;

  keyhash_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] m_hash [4];
  logic [63:0] m_fc;
  logic        m_act;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic m_allowed();
    return !m_act || (m_fc[17] && m_fc[0]);
  endfunction

  function automatic logic [63:0] m_read(logic [11:0] a);
    if (a == FC_A) return m_fc;
    if (a == ACT_A) return {63'b0, m_act};
    if (a >= HB && a < HB + 12'd4) return m_hash[a - HB];
    return '0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_wr = 1'b0; req_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) m_hash[i] = DEF[i*64 +: 64];
    m_fc = '0;
    m_act = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    logic  exp_err;
    string tag;
    exp_err = 1'b0;
    tag = "R10";
    if (a == FC_A) begin
      if (m_fc[0]) begin exp_err = 1'b1; tag = "R6"; end
      else m_fc = m_act ? d : (d & ~((64'd1 << 17) | (64'd1 << 18)));
    end else if (a == ACT_A) begin
      if (d[0]) m_act = 1'b1;
    end else if (a >= HB && a < HB + 12'd4) begin
      if (m_allowed()) m_hash[a - HB] = d;
      else begin exp_err = 1'b1; tag = "R4"; end
    end
    @(negedge clk);
    req_wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    check(tag, {63'b0, err}, {63'b0, exp_err});
    @(negedge clk);
    check("R4", {63'b0, err}, 64'd0);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    @(negedge clk);
    req_rd = 1'b1; addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    check(tag, rdata, m_read(a));
  endtask

  function automatic logic [11:0] pick_addr(int k);
    case (k)
      0: return ACT_A;
      1: return FC_A;
      6: return UNM_A;
      default: return HB + 12'(k - 2);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: reset state
    check("R1", {63'b0, err}, 64'd0);
    rd(FC_A, "R1");
    rd(ACT_A, "R1");
    // R9: default digest words
    for (int i = 0; i < 4; i++) rd(HB + 12'(i), "R9");
    rd(UNM_A, "R8");
    // R2: pre-activation digest writes accepted
    wr(HB + 12'd1, 64'hdead_beef_0000_0001);
    rd(HB + 12'd1, "R2");
    // R5: enclave bits cleared before activation
    wr(FC_A, 64'h0000_0000_0006_0f00);
    rd(FC_A, "R5");
    // R7: writing 0 does not activate
    wr(ACT_A, 64'hffff_ffff_ffff_fffe);
    rd(ACT_A, "R7");
    wr(HB + 12'd3, 64'h1234_5678_9abc_def0);
    rd(HB + 12'd3, "R2");
    wr(ACT_A, 64'd1);
    rd(ACT_A, "R7");
    // R3/R4: rejected after activation without launch control
    wr(HB + 12'd0, 64'h5555_aaaa_5555_aaaa);
    rd(HB + 12'd0, "R3");
    // R3: launch control without lock still rejects
    wr(FC_A, 64'h0000_0000_0002_0000);
    rd(FC_A, "R5");
    wr(HB + 12'd2, 64'h0f0f_0f0f_0f0f_0f0f);
    rd(HB + 12'd2, "R3");
    // R3: launch control and lock accept
    wr(FC_A, 64'h0000_0000_0002_0001);
    wr(HB + 12'd2, 64'hf0f0_f0f0_f0f0_f0f0);
    rd(HB + 12'd2, "R3");
    // R6: locked control refuses writes
    wr(FC_A, 64'd0);
    rd(FC_A, "R6");
    // R7: stays set after writing 0
    wr(ACT_A, 64'd0);
    rd(ACT_A, "R7");
    rd(UNM_A, "R8");
    // R3: lock without launch control after activation
    do_reset();
    wr(ACT_A, 64'd1);
    wr(FC_A, 64'd1);
    wr(HB + 12'd1, 64'h7777_7777_7777_7777);
    rd(HB + 12'd1, "R3");

    // constrained random episodes
    for (int ep = 0; ep < 10; ep++) begin
      do_reset();
      for (int k = 0; k < 60; k++) begin
        int          r;
        logic [11:0] a;
        logic [63:0] d;
        r = $urandom_range(0, 99);
        d = {$urandom(), $urandom()};
        if (r < 10) begin
          a = ACT_A;
          d[0] = ($urandom_range(0, 2) == 0);
        end else if (r < 35) begin
          a = FC_A;
          d[0] = ($urandom_range(0, 5) == 0);
          d[17] = ($urandom_range(0, 3) != 0);
        end else if (r < 80) begin
          a = HB + 12'($urandom_range(0, 3));
        end else if (r < 85) begin
          a = UNM_A;
        end else begin
          a = pick_addr($urandom_range(0, 6));
          rd(a, "R8");
          continue;
        end
        wr(a, d);
        rd(a, "R8");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule